// File: doc/BRIEF.md
# Pipeline Exception Arbiter and Vectoring Unit

This block sits beside a five-stage in-order pipeline and decides, every cycle, whether the pipeline must leave its normal flow. The fetch, decode, execute and memory stages each provide a ready-made fault flag and the PC of the instruction they hold. The write-back stage cannot fault, so it has no input. An external interrupt line and a one-cycle return strobe complete the inputs. When several stages fault in the same cycle, the instruction furthest down the pipeline wins. The unit then records that instruction's PC and a reason code, redirects fetch to a handler address that depends on the reason, and bubbles the faulting stage and every younger stage in that same cycle.

A small sequencer has two states. In `ST_RUN` the unit reacts to requests. Taking an exception or executing a return moves it to `ST_DRAIN` (transition *take* or *return*). `ST_DRAIN` lasts exactly one cycle. In that cycle every request is ignored while the flushed pipeline refills, and the sequencer goes back to `ST_RUN` unconditionally (transition *resume*). Reset places the sequencer in `ST_RUN`. Priority inside `ST_RUN` is: an internal fault first, then the interrupt, then the return.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, `epc_o` and `cause_o` are zero, and `redirect_o` and `flush_o` are low.
- R2: When several fault flags are high in one cycle, the oldest stage is taken. The order is memory, then execute, then decode, then fetch.
- R3: On the clock edge that ends the cycle in which a fault is taken, `epc_o` loads the full 32-bit PC of the faulting stage.
- R4: `cause_o` holds the reason code in bits [6:2], and all other bits are zero. The codes are: interrupt 0, fetch address fault 4, data address fault 5, reserved instruction 10, overflow 12. These come from the fetch, memory, decode and execute stages respectively.
- R5: A reserved-instruction fault redirects fetch to 0x8000_0000. Every other taken event (overflow, memory faults, interrupt) redirects to 0x8000_0180.
- R6: In the cycle an event is taken, `flush_o` marks the selected stage and all younger stages. Bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory. `redirect_o` is high in that same cycle.
- R7: The interrupt is taken only when no fault flag is high. Its cause is 0, and its EPC is the PC of the oldest stage whose valid bit is set. If no stage is valid, the fetch PC is used.
- R8: A return strobe with no pending fault or interrupt raises `redirect_o` with `redirect_pc_o` equal to `epc_o`. No stage is flushed, and EPC and cause are left unchanged.
- R9: `redirect_o` is a single-cycle pulse. In the cycle after any redirect, all requests are ignored and `redirect_o` and `flush_o` stay low.
- R10: EPC and cause keep their values in every cycle in which no fault or interrupt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_if_i | input | 1 | Fetch stage: instruction address fault |
| fault_id_i | input | 1 | Decode stage: reserved instruction |
| fault_ex_i | input | 1 | Execute stage: arithmetic overflow |
| fault_mem_i | input | 1 | Memory stage: data address fault |
| pc_if_i | input | 32 | PC held in fetch |
| pc_id_i | input | 32 | PC held in decode |
| pc_ex_i | input | 32 | PC held in execute |
| pc_mem_i | input | 32 | PC held in memory |
| stg_valid_i | input | 4 | Per-stage occupancy (bit 0 fetch … bit 3 memory) |
| irq_i | input | 1 | External interrupt request |
| eret_i | input | 1 | Return-from-handler strobe |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| flush_o | output | 4 | Per-stage bubble request |
| epc_o | output | 32 | Saved exception PC |
| cause_o | output | 32 | Cause register |

## Verification
The bench builds the unit with its default parameters: a 32-bit PC, a 5-bit code field at bit 2, and the two handler vectors 0x8000_0000 and 0x8000_0180. Because the two vectors differ, a swapped vector choice shows up directly on `redirect_pc_o`. Because the code field starts above bit 0, a misplaced shift shows up in `cause_o`. The bench also drives overlapping fault sets, an interrupt with partial stage occupancy, and an interrupt that competes with a fault, so every arm of the priority logic is reached.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NSTG = 4;
    localparam int CODE_W = 5;

    typedef enum logic [CODE_W-1:0] {
        CC_IRQ   = 5'd0,
        CC_FETCH = 5'd4,
        CC_DATA  = 5'd5,
        CC_RSVD  = 5'd10,
        CC_OVF   = 5'd12
    } cause_code_e;

    typedef enum logic {
        ST_RUN,
        ST_DRAIN
    } seq_state_e;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_pkg::*;
#(
    parameter int PC_W = 32,
    parameter logic [PC_W-1:0] VEC_BASE = 32'h8000_0000,
    parameter logic [PC_W-1:0] VEC_GEN  = 32'h8000_0180
) (
    input  logic [NSTG-1:0]        fault_i,
    input  logic [NSTG-1:0][PC_W-1:0] pc_i,
    input  logic [NSTG-1:0]        valid_i,
    input  logic                   irq_i,
    output logic                   req_o,
    output logic [PC_W-1:0]        pc_o,
    output cause_code_e            code_o,
    output logic [NSTG-1:0]        mask_o,
    output logic [PC_W-1:0]        vec_o
);
    localparam int SEL_W = $clog2(NSTG);

    logic [SEL_W-1:0] fault_sel;
    logic [SEL_W-1:0] live_sel;
    logic [SEL_W-1:0] sel;
    logic             fault_hit;
    cause_code_e      stg_code [NSTG];

    // Stage order: index 0 fetch (youngest) .. NSTG-1 memory (oldest)
    assign stg_code[0] = CC_FETCH;
    assign stg_code[1] = CC_RSVD;
    assign stg_code[2] = CC_OVF;
    assign stg_code[3] = CC_DATA;

    // Ascending scan: the last hit, i.e. the oldest stage, wins
    always_comb begin
        fault_hit = 1'b0;
        fault_sel = '0;
        live_sel  = '0;
        for (int s = 0; s < NSTG; s++) begin
            if (fault_i[s]) begin
                fault_hit = 1'b1;
                fault_sel = SEL_W'(s);
            end
            if (valid_i[s]) begin
                live_sel = SEL_W'(s);
            end
        end
    end

    assign sel    = fault_hit ? fault_sel : live_sel;
    assign req_o  = fault_hit | irq_i;
    assign pc_o   = pc_i[sel];
    assign code_o = fault_hit ? stg_code[sel] : CC_IRQ;
    assign vec_o  = (code_o == CC_RSVD) ? VEC_BASE : VEC_GEN;

    genvar g;
    generate
        for (g = 0; g < NSTG; g++) begin : g_mask
            assign mask_o[g] = (SEL_W'(g) <= sel);
        end
    endgenerate
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ret_i,
    output logic take_o,
    output logic ret_go_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (req_i || ret_i) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        take_o   = 1'b0;
        ret_go_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                take_o   = req_i;
                ret_go_o = ret_i && !req_i;
            end
            ST_DRAIN: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int CAUSE_W  = 32,
    parameter int CODE_LSB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [PC_W-1:0]    pc_i,
    input  cause_code_e        code_i,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [PC_W-1:0]    epc_q;
    logic [CAUSE_W-1:0] cause_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (load_i) begin
            epc_q   <= pc_i;
            cause_q <= CAUSE_W'(code_i) << CODE_LSB;
        end
    end

    assign epc_o   = epc_q;
    assign cause_o = cause_q;

    AST_HOLD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(epc_q) && $stable(cause_q))); // R10
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int CAUSE_W  = 32,
    parameter int CODE_LSB = 2,
    parameter logic [PC_W-1:0] VEC_BASE = 32'h8000_0000,
    parameter logic [PC_W-1:0] VEC_GEN  = 32'h8000_0180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_if_i,
    input  logic               fault_id_i,
    input  logic               fault_ex_i,
    input  logic               fault_mem_i,
    input  logic [PC_W-1:0]    pc_if_i,
    input  logic [PC_W-1:0]    pc_id_i,
    input  logic [PC_W-1:0]    pc_ex_i,
    input  logic [PC_W-1:0]    pc_mem_i,
    input  logic [3:0]         stg_valid_i,
    input  logic               irq_i,
    input  logic               eret_i,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o,
    output logic [3:0]         flush_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [NSTG-1:0]            fault_vec;
    logic [NSTG-1:0][PC_W-1:0]  pc_vec;
    logic                       req;
    logic [PC_W-1:0]            sel_pc;
    cause_code_e                sel_code;
    logic [NSTG-1:0]            sel_mask;
    logic [PC_W-1:0]            sel_vec;
    logic                       take;
    logic                       ret_go;

    assign fault_vec = {fault_mem_i, fault_ex_i, fault_id_i, fault_if_i};
    assign pc_vec    = {pc_mem_i, pc_ex_i, pc_id_i, pc_if_i};

    exc_prio_sel #(
        .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_GEN(VEC_GEN)
    ) u_sel (
        .fault_i(fault_vec), .pc_i(pc_vec), .valid_i(stg_valid_i),
        .irq_i(irq_i), .req_o(req), .pc_o(sel_pc), .code_o(sel_code),
        .mask_o(sel_mask), .vec_o(sel_vec)
    );

    exc_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ret_i(eret_i),
        .take_o(take), .ret_go_o(ret_go)
    );

    exc_state_regs #(
        .PC_W(PC_W), .CAUSE_W(CAUSE_W), .CODE_LSB(CODE_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .load_i(take), .pc_i(sel_pc),
        .code_i(sel_code), .epc_o(epc_o), .cause_o(cause_o)
    );

    assign redirect_o    = take | ret_go;
    assign redirect_pc_o = take ? sel_vec : epc_o;
    assign flush_o       = take ? sel_mask : '0;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> (!redirect_o && flush_o == '0)); // R9
    AST_FLUSH_NEEDS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o != '0) |-> redirect_o); // R6
    AST_MEM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_mem_i && flush_o != '0) |-> (flush_o == 4'b1111)); // R2
    AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && flush_o == '0) |-> (redirect_pc_o == epc_o)); // R8
    AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && flush_o != '0) |=>
        ((cause_o[CODE_LSB +: CODE_W] == CC_RSVD) == ($past(redirect_pc_o) == VEC_BASE))); // R5
endmodule

// File: tb/tb_exc_ctrl_unit.sv
`timescale 1ns/1ps
module tb_exc_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        f_if, f_id, f_ex, f_mem;
    logic [31:0] p_if, p_id, p_ex, p_mem;
    logic [3:0]  vld;
    logic        irq, eret;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic [3:0]  flush;
    logic [31:0] epc, cause;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    exc_ctrl_unit dut (
        .clk(clk), .rst_n(rst_n),
        .fault_if_i(f_if), .fault_id_i(f_id), .fault_ex_i(f_ex), .fault_mem_i(f_mem),
        .pc_if_i(p_if), .pc_id_i(p_id), .pc_ex_i(p_ex), .pc_mem_i(p_mem),
        .stg_valid_i(vld), .irq_i(irq), .eret_i(eret),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc), .flush_o(flush),
        .epc_o(epc), .cause_o(cause)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs;
        {f_if, f_id, f_ex, f_mem, irq, eret} = '0;
    endtask

    // Drive a request pattern, check the take cycle, then the drain cycle.
    task automatic run_take(input logic [3:0] fv, input bit ir, input bit er,
                            input logic [3:0] v, input logic [3:0] exp_mask,
                            input logic [31:0] exp_vec, input logic [31:0] exp_pc,
                            input logic [31:0] exp_cause, input string req);
        @(negedge clk);
        {f_mem, f_ex, f_id, f_if} = fv;
        irq = ir; eret = er; vld = v;
        #1;
        chk(redirect === 1'b1, req, "redirect", {31'd0, redirect}, 32'd1);
        chk(flush === exp_mask, req, "flush", {28'd0, flush}, {28'd0, exp_mask});
        chk(redirect_pc === exp_vec, req, "vector", redirect_pc, exp_vec);
        @(posedge clk); #1;
        chk(epc === exp_pc, req, "epc", epc, exp_pc);
        chk(cause === exp_cause, req, "cause", cause, exp_cause);
        // R9: inputs still held, drain cycle ignores them
        chk(redirect === 1'b0 && flush === 4'b0, "R9", "drain quiet",
            {27'd0, redirect, flush}, 32'd0);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset;
        chk(epc === 32'd0, "R1", "epc", epc, 32'd0);
        chk(cause === 32'd0, "R1", "cause", cause, 32'd0);
        chk(redirect === 1'b0 && flush === 4'b0, "R1", "redirect/flush",
            {27'd0, redirect, flush}, 32'd0);
    endtask

    task automatic t_single_faults;
        // R3 R4 R5 R6 per stage
        run_take(4'b0001, 0, 0, 4'hF, 4'b0001, 32'h8000_0180, p_if,  32'h10, "R3_R4_fetch");
        run_take(4'b0010, 0, 0, 4'hF, 4'b0011, 32'h8000_0000, p_id,  32'h28, "R5_R6_decode");
        run_take(4'b0100, 0, 0, 4'hF, 4'b0111, 32'h8000_0180, p_ex,  32'h30, "R4_R6_execute");
        run_take(4'b1000, 0, 0, 4'hF, 4'b1111, 32'h8000_0180, p_mem, 32'h14, "R3_R5_memory");
    endtask

    task automatic t_multi_faults;
        run_take(4'b1111, 0, 0, 4'hF, 4'b1111, 32'h8000_0180, p_mem, 32'h14, "R2_all");
        run_take(4'b0111, 0, 0, 4'hF, 4'b0111, 32'h8000_0180, p_ex,  32'h30, "R2_ex_id_if");
        run_take(4'b0011, 0, 0, 4'hF, 4'b0011, 32'h8000_0000, p_id,  32'h28, "R2_id_if");
        run_take(4'b0101, 1, 1, 4'hF, 4'b0111, 32'h8000_0180, p_ex,  32'h30, "R2_fault_over_irq_ret");
    endtask

    task automatic t_interrupt;
        run_take(4'b0000, 1, 0, 4'b0110, 4'b0111, 32'h8000_0180, p_ex,  32'h0, "R7_partial");
        run_take(4'b0000, 1, 0, 4'b0000, 4'b0001, 32'h8000_0180, p_if,  32'h0, "R7_empty");
        run_take(4'b0010, 1, 0, 4'hF,    4'b0011, 32'h8000_0000, p_id,  32'h28, "R7_fault_wins");
    endtask

    task automatic t_return;
        logic [31:0] e0, c0;
        e0 = epc; c0 = cause;
        @(negedge clk);
        eret = 1'b1;
        #1;
        chk(redirect === 1'b1, "R8", "redirect", {31'd0, redirect}, 32'd1);
        chk(redirect_pc === e0, "R8", "target", redirect_pc, e0);
        chk(flush === 4'b0, "R8", "flush", {28'd0, flush}, 32'd0);
        @(posedge clk); #1;
        chk(epc === e0 && cause === c0, "R8", "regs kept", epc, e0);
        chk(redirect === 1'b0, "R9", "ret pulse", {31'd0, redirect}, 32'd0);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_hold;
        logic [31:0] e0, c0;
        e0 = epc; c0 = cause;
        repeat (5) @(negedge clk);
        chk(epc === e0, "R10", "epc hold", epc, e0);
        chk(cause === c0, "R10", "cause hold", cause, c0);
        chk(redirect === 1'b0, "R10", "no redirect idle", {31'd0, redirect}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        vld = 4'hF;
        p_if = 32'h0040_0010; p_id = 32'h0040_000C;
        p_ex = 32'h0040_0008; p_mem = 32'h0040_0004;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_single_faults();
        t_multi_faults();
        t_interrupt();
        t_return();
        t_hold();
        p_ex = 32'hDEAD_BEE0;
        run_take(4'b0100, 0, 0, 4'hF, 4'b0111, 32'h8000_0180, 32'hDEAD_BEE0, 32'h30, "R3_fullpc");
        t_return();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule